// File: doc/BRIEF.md
# Snooping Cache Coherence Controller

This block keeps the coherence state of a small direct-mapped cache that shares a snooping bus with other caches. The cache is write-back and uses write-invalidate. Each line records a tag and one of three states:

- Invalid: the line holds nothing.
- Shared: the line is a read-only copy.
- Exclusive: the line is the only copy, may be written, and is dirty.

There is no clean-exclusive state. Any write to a line that is not Exclusive goes to the bus as a miss.

On the processor side, a request gives an address and a read/write flag. The block looks up the tag array and answers a hit in the same cycle. A miss is held in a single pending slot. From that slot the block asks for the bus and issues a write-back of a dirty victim (if there is one), then the read-miss or write-miss. On the snoop side, the block watches transactions from other caches. It invalidates or downgrades its copy, and when it owns dirty data it raises the write-back and abort-memory outputs.

Addresses are `{tag, index}`. The index is the low `IDX_W` bits and the tag is the upper `TAG_W` bits. The bus command code is 2'b00 for none, 2'b01 for read-miss, 2'b10 for write-miss and 2'b11 for write-back. The same codes are used on the bus output and the snoop input.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any line misses, even with tag 0.
- R2: A read that misses puts a read-miss (2'b01) with the request address on the bus and leaves the line Shared with the new tag.
- R3: A write to a line that is not Exclusive with a matching tag, including a Shared hit, puts a write-miss (2'b10) with the request address on the bus and leaves the line Exclusive.
- R4: A read hit in Shared or Exclusive, or a write hit in Exclusive, raises `cpu_ready` and `cpu_hit` in the request cycle with no bus request and no state change.
- R5: A snooped write-miss that matches a Shared line makes it Invalid and raises no write-back.
- R6: A snooped read-miss that matches an Exclusive line raises `snp_wb` and `snp_abort` in that cycle and leaves the line Shared.
- R7: A snooped write-miss that matches an Exclusive line raises `snp_wb` and `snp_abort` in that cycle and leaves the line Invalid.
- R8: A miss whose line is Exclusive under another tag first issues a write-back (2'b11) of the old address and then the miss, one granted cycle later.
- R9: A cycle with `snp_valid` high neither completes a processor request nor takes a bus grant. The request completes in a later cycle.
- R10: A snoop with a mismatched tag, an Invalid line, a read-miss on a Shared line, or a write-back command changes no state and raises no write-back.
- R11: A miss is captured in the request cycle. `bus_req` is high from the next cycle until the final grant, and `cpu_ready` rises in the cycle that grants the miss transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | TAG_W+IDX_W | Request address {tag, index} |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Request completed as a hit with no bus traffic |
| bus_req | output | 1 | Pending bus transaction |
| bus_cmd | output | 2 | Command of the pending transaction |
| bus_addr | output | TAG_W+IDX_W | Address of the pending transaction |
| bus_gnt | input | 1 | Bus grant; the transaction is issued in a granted cycle |
| snp_valid | input | 1 | Transaction from another cache is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | TAG_W+IDX_W | Snooped address |
| snp_wb | output | 1 | This cache supplies dirty data for the snooped line |
| snp_abort | output | 1 | Memory must abort its response to the snooped transaction |

## Verification
The assertions assume the processor holds `cpu_req`, `cpu_we` and `cpu_addr` steady from request to `cpu_ready`. They also assume a granted cycle counts only when no snoop is present, because the bus carries one transaction at a time. The stimulus drops the request in the cycle after completion and raises `bus_gnt` together with `snp_valid` only in the deliberate priority case, where the design has to ignore the grant. The sweep brings every line into each of the three states with varied tags and grant delays. It then probes the resulting state through read and write requests and their bus traffic.

// File: rtl/snoop_coh_ctrl.sv
`timescale 1ns/1ps
module snoop_coh_ctrl #(
  parameter int TAG_W = 4,
  parameter int IDX_W = 2,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_wb,
  output logic              snp_abort
);
  localparam int LINES = 1 << IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2;
  localparam logic [1:0] CMD_NONE = 2'b00, CMD_RM = 2'b01, CMD_WM = 2'b10, CMD_WB = 2'b11;

  logic [LINES-1:0][1:0]       st_q;
  logic [LINES-1:0][TAG_W-1:0] tag_q;
  logic                        pend_q, pwe_q;
  logic [ADDR_W-1:0]           paddr_q;

  logic [IDX_W-1:0] c_idx, p_idx, s_idx;
  logic [TAG_W-1:0] c_tag, p_tag, s_tag;
  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign p_idx = paddr_q[IDX_W-1:0];
  assign p_tag = paddr_q[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  logic c_match, c_fast, take;
  assign c_match = (st_q[c_idx] != ST_I) && (tag_q[c_idx] == c_tag);
  assign c_fast  = c_match && (!cpu_we || st_q[c_idx] == ST_E);
  assign take    = cpu_req && !pend_q && !snp_valid;

  logic victim, fire, done_miss;
  assign victim    = (st_q[p_idx] == ST_E) && (tag_q[p_idx] != p_tag);
  assign fire      = pend_q && bus_gnt && !snp_valid;
  assign done_miss = fire && !victim;

  assign bus_req  = pend_q;
  assign bus_cmd  = !pend_q ? CMD_NONE : victim ? CMD_WB : pwe_q ? CMD_WM : CMD_RM;
  assign bus_addr = victim ? {tag_q[p_idx], p_idx} : paddr_q;

  assign cpu_hit   = take && c_fast;
  assign cpu_ready = cpu_hit || done_miss;

  logic s_match, s_owner;
  assign s_match   = (st_q[s_idx] != ST_I) && (tag_q[s_idx] == s_tag);
  assign s_owner   = s_match && (st_q[s_idx] == ST_E) && (snp_cmd == CMD_RM || snp_cmd == CMD_WM);
  assign snp_wb    = snp_valid && s_owner;
  assign snp_abort = snp_wb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      tag_q   <= '0;
      pend_q  <= 1'b0;
      pwe_q   <= 1'b0;
      paddr_q <= '0;
    end else if (snp_valid) begin
      if (s_match && snp_cmd == CMD_WM)
        st_q[s_idx] <= ST_I;
      else if (s_match && snp_cmd == CMD_RM && st_q[s_idx] == ST_E)
        st_q[s_idx] <= ST_S;
    end else if (fire) begin
      if (victim) begin
        st_q[p_idx] <= ST_I;
      end else begin
        st_q[p_idx]  <= pwe_q ? ST_E : ST_S;
        tag_q[p_idx] <= p_tag;
        pend_q       <= 1'b0;
      end
    end else if (take && !c_fast) begin
      pend_q  <= 1'b1;
      pwe_q   <= cpu_we;
      paddr_q <= cpu_addr;
    end
  end
endmodule

// File: rtl/snoop_coh_ctrl_chk.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_chk #(
  parameter int TAG_W = 4,
  parameter int IDX_W = 2,
  localparam int ADDR_W = TAG_W + IDX_W,
  localparam int LINES = 1 << IDX_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cpu_ready,
  input logic                        cpu_hit,
  input logic                        bus_req,
  input logic [1:0]                  bus_cmd,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_gnt,
  input logic                        snp_valid,
  input logic [1:0]                  snp_cmd,
  input logic [ADDR_W-1:0]           snp_addr,
  input logic                        snp_wb,
  input logic                        snp_abort,
  input logic [LINES-1:0][1:0]       st_q,
  input logic [LINES-1:0][TAG_W-1:0] tag_q
);
  logic [IDX_W-1:0] s_idx, s_idx_q, b_idx_q;
  logic fired, s_hit;
  assign s_idx = snp_addr[IDX_W-1:0];
  assign fired = bus_req && bus_gnt && !snp_valid;
  assign s_hit = (st_q[s_idx] != 2'd0) && (tag_q[s_idx] == snp_addr[ADDR_W-1:IDX_W]);

  always_ff @(posedge clk) begin
    s_idx_q <= s_idx;
    b_idx_q <= bus_addr[IDX_W-1:0];
  end

  assert_readmiss_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fired && bus_cmd == 2'b01 |=> st_q[b_idx_q] == 2'd1);
  assert_writemiss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fired && bus_cmd == 2'b10 |=> st_q[b_idx_q] == 2'd2);
  assert_hit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> cpu_ready && !bus_req);
  assert_snoop_inval_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_cmd == 2'b10 && s_hit |=> st_q[s_idx_q] == 2'd0);
  assert_owner_share_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb && snp_cmd == 2'b01 |=> st_q[s_idx_q] == 2'd1);
  assert_owner_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb |-> snp_abort && snp_valid && st_q[s_idx] == 2'd2);
  assert_wb_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_cmd == 2'b11 |-> !cpu_ready);
  assert_snoop_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready);
  assert_snoop_nomatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !s_hit |=> $stable(st_q));
endmodule

bind snoop_coh_ctrl snoop_coh_ctrl_chk #(.TAG_W(TAG_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
  .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
  .snp_wb(snp_wb), .snp_abort(snp_abort), .st_q(st_q), .tag_q(tag_q));

// File: tb/snoop_coh_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_tb_top;
  localparam int TW = 4, IW = 2, AW = TW + IW, NL = 1 << IW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, cpu_req = 1'b0, cpu_we = 1'b0, bus_gnt = 1'b0, snp_valid = 1'b0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [1:0] snp_cmd = '0;
  logic cpu_ready, cpu_hit, bus_req, snp_wb, snp_abort;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;

  snoop_coh_ctrl #(.TAG_W(TW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_gnt(bus_gnt), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_wb(snp_wb), .snp_abort(snp_abort));

  int checks = 0, errors = 0;
  bit finished = 0;
  int ms[NL];
  int mt[NL];

  function automatic int mkaddr(input int tg, input int ix);
    return (tg % (1 << TW)) * NL + ix;
  endfunction

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input int tg, input int ix, input int gap, input string lbl);
    int xc[2];
    int xa[2];
    int nx, cyc, enx, elat;
    bit got, hs, reqok, ehit, evic;
    string l;
    xc[0] = 0; xc[1] = 0; xa[0] = 0; xa[1] = 0;
    nx = 0; cyc = -1; got = 0; hs = 0; reqok = 1;
    ehit = ms[ix] != 0 && mt[ix] == tg && (!we || ms[ix] == 2);
    evic = !ehit && ms[ix] == 2 && mt[ix] != tg;
    l = lbl != "" ? lbl : ehit ? "R4" : evic ? "R8" : we ? "R3" : "R2";
    for (int c = 0; c < 20 && !got; c++) begin
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(mkaddr(tg, ix)); bus_gnt = (c >= gap);
      #1;
      if (c >= 1 && !bus_req) reqok = 0;
      if (bus_req && bus_gnt && nx < 2) begin xc[nx] = bus_cmd; xa[nx] = bus_addr; nx++; end
      if (cpu_ready) begin got = 1; hs = cpu_hit; cyc = c; end
    end
    @(negedge clk);
    cpu_req = 1'b0; bus_gnt = 1'b0;
    enx  = ehit ? 0 : evic ? 2 : 1;
    elat = ehit ? 0 : (gap < 1 ? 1 : gap) + (evic ? 1 : 0);
    check(got, "R11", got, 1);
    check(hs == ehit, l, hs, ehit);
    check(nx == enx, l, nx, enx);
    check(cyc == elat, "R11", cyc, elat);
    check(reqok, "R11", reqok, 1);
    if (evic) begin
      check(xc[0] == 3 && xa[0] == mkaddr(mt[ix], ix), "R8", xc[0] * 256 + xa[0], 3 * 256 + mkaddr(mt[ix], ix));
      check(xc[1] == (we ? 2 : 1) && xa[1] == mkaddr(tg, ix), l, xc[1] * 256 + xa[1], (we ? 2 : 1) * 256 + mkaddr(tg, ix));
    end else if (!ehit) begin
      check(xc[0] == (we ? 2 : 1) && xa[0] == mkaddr(tg, ix), l, xc[0] * 256 + xa[0], (we ? 2 : 1) * 256 + mkaddr(tg, ix));
    end
    if (!ehit) begin ms[ix] = we ? 2 : 1; mt[ix] = tg; end
  endtask

  task automatic snoop(input int cmd, input int tg, input int ix);
    bit m, ewb;
    string l;
    m = ms[ix] != 0 && mt[ix] == tg;
    ewb = m && ms[ix] == 2 && (cmd == 1 || cmd == 2);
    l = !m ? "R10" : (ms[ix] == 2 && cmd == 1) ? "R6" : (ms[ix] == 2 && cmd == 2) ? "R7" :
        (ms[ix] == 1 && cmd == 2) ? "R5" : "R10";
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = AW'(mkaddr(tg, ix));
    #1;
    check(snp_wb == ewb, l, snp_wb, ewb);
    check(snp_abort == ewb, l, snp_abort, ewb);
    if (m && cmd == 2) ms[ix] = 0;
    else if (m && cmd == 1 && ms[ix] == 2) ms[ix] = 1;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin ms[i] = 0; mt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: tag 0 equals the cleared tag, so only the Invalid state makes these miss
    for (int ix = 0; ix < NL; ix++) cpu_op(1'b0, 0, ix, 0, "R1");

    for (int ix = 0; ix < NL; ix++)
      for (int p = 0; p < 3; p++)
        for (int op = 0; op < 8; op++) begin
          int t, o, g;
          t = (ix * 3 + p + op) % 15 + 1;
          o = (t + 7) % 16;
          g = (ix + op) % 3;
          cpu_op(1'b0, t, ix, g, "");
          if (p == 0) snoop(2, t, ix);
          if (p == 2) cpu_op(1'b1, t, ix, 0, "");
          case (op)
            0: cpu_op(1'b0, t, ix, g, "");
            1: cpu_op(1'b1, t, ix, g, "");
            2: cpu_op(1'b0, o, ix, g, "");
            3: cpu_op(1'b1, o, ix, g, "");
            4: snoop(1, t, ix);
            5: snoop(2, t, ix);
            6: snoop(1, o, ix);
            default: snoop(3, t, ix);
          endcase
          cpu_op(1'b0, t, ix, 0, "");
          cpu_op(1'b1, t, ix, 1, "");
        end

    // Snoop on the dirty victim while its write-back waits for the bus (R8, R7, R9)
    cpu_op(1'b1, 1, 0, 0, "");
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(mkaddr(2, 0)); bus_gnt = 1'b0;
    #1 check(!cpu_ready && !bus_req, "R11", cpu_ready, 0);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'b10; snp_addr = AW'(mkaddr(1, 0)); bus_gnt = 1'b1;
    #1;
    check(bus_req && bus_cmd == 2'b11, "R8", bus_cmd, 3);
    check(snp_wb && snp_abort, "R7", snp_wb, 1);
    check(!cpu_ready, "R9", cpu_ready, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    check(bus_req && bus_cmd == 2'b01 && bus_addr == AW'(mkaddr(2, 0)), "R9", bus_cmd * 256 + bus_addr, 256 + mkaddr(2, 0));
    check(cpu_ready && !cpu_hit, "R2", cpu_ready, 1);
    @(negedge clk);
    cpu_req = 1'b0; bus_gnt = 1'b0;
    ms[0] = 1; mt[0] = 2;
    cpu_op(1'b0, 2, 0, 0, "");

    // A hit stalls for one cycle while a snoop is on the bus (R9)
    cpu_op(1'b1, 3, 1, 0, "");
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(mkaddr(3, 1));
    snp_valid = 1'b1; snp_cmd = 2'b11; snp_addr = AW'(mkaddr(3, 1));
    #1;
    check(!cpu_ready, "R9", cpu_ready, 0);
    check(!snp_wb, "R10", snp_wb, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1 check(cpu_ready && cpu_hit, "R9", cpu_ready, 1);
    @(negedge clk);
    cpu_req = 1'b0;
    cpu_op(1'b1, 3, 1, 0, "R10");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule